// File: doc/BRIEF.md
# Counter-Based Gate Delay Meter

This block measures how long one two-input XOR gate takes to respond to a rising input. It owns the two lines that drive the gate and watches the gate's output. Each measurement starts from a known quiet point. Both drive lines are held low for a settle interval, so the gate sits at an output of 0. The block then raises exactly one of the two drive lines and counts system clock cycles. Counting goes on while the raised line and the gate output still disagree. It stops once the output is seen high.

The gate output is asynchronous to the meter, so it passes through a synchronizer before it reaches the enable logic. The synchronizer adds a fixed latency to every reading: the reported count is the delay in whole clock cycles plus the number of synchronizer stages (2 by default). Software that uses the reading subtracts this offset. It can repeat a measurement with the other input selected to obtain the second path delay.

The count stays on its output until the next start. A one-cycle done pulse marks the end of each measurement. If the gate output never rises, the counter stops at its all-ones value and a timeout flag is raised with done.

Top module: `gate_delay_meter`

## Requirements
- R1: After reset, both drive lines are 0, the count is 0, and done and timeout are 0.
- R2: A start pulse taken while idle clears the count to 0 and clears timeout. Both drive lines are then held at 0 for SETTLE_CYC cycles (default 16) before the selected line is raised.
- R3: When sel is 0, only drive_a rises; when sel is 1, only drive_b rises. The two drive lines are never high together.
- R4: During a measurement the count advances by exactly one per clock while the raised line and the synchronized gate output differ. It stops advancing once the synchronized output is high.
- R5: If the gate output rises D clock edges after the selected drive line rises, the reading is D + 2 (two synchronizer stages).
- R6: Done is high for exactly one cycle when counting stops. Both drive lines return to 0 in that same cycle.
- R7: The count holds its final value after done until the next accepted start.
- R8: If the gate output never rises, the count stops at 4095, timeout is set to 1, and done pulses.
- R9: A start pulse that arrives while a measurement is in progress is ignored. The measurement and its reading are unaffected.
- R10: A measurement with sel = 1 uses the same sequence with the roles of the two inputs swapped, and reports the delay of the path from drive_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counting reference |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| sel_i | input | 1 | Input to measure: 0 = drive_a path, 1 = drive_b path |
| gate_out_i | input | 1 | Output of the gate under test (asynchronous) |
| drive_a_o | output | 1 | Drive line to the gate's first input |
| drive_b_o | output | 1 | Drive line to the gate's second input |
| count_o | output | 12 | Delay reading in clock cycles, including the synchronizer offset |
| done_o | output | 1 | One-cycle pulse when a measurement ends |
| timeout_o | output | 1 | Set when the count saturated without the output rising |

## Verification
On every cycle, the assertions check the following:
- the two drive lines are never high together;
- the lines stay low through the settle interval;
- the count only ever steps up by one, except when a start clears it;
- the count is frozen whenever counting is not enabled;
- done never lasts two cycles;
- a timeout always arrives together with done.

Only the bench's scenarios can show the rest:
- that a reading equals the modelled delay plus the synchronizer offset, for each input and for several delays;
- that saturation happens at exactly 4095;
- that a start arriving mid-measurement leaves the reading unchanged.

// File: rtl/gdm_pkg.sv
package gdm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_MEASURE = 2'd2
  } gdm_state_e;
endpackage

// File: rtl/gdm_sync.sv
module gdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gdm_counter.sv
module gdm_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                          count_q <= '0;
    else if (clr_i)                   count_q <= '0;
    else if (en_i && count_q != CNT_MAX) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign sat_o   = (count_q == CNT_MAX);

  // R4: outside a clear, the count only moves up by one
  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    ((count_q != $past(count_q)) && !$past(clr_i)) |-> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/gdm_ctrl.sv
module gdm_ctrl
  import gdm_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sel_i,
  input  logic gate_seen_i,
  input  logic sat_i,
  output logic cnt_clr_o,
  output logic cnt_en_o,
  output logic drive_a_o,
  output logic drive_b_o,
  output logic done_o,
  output logic timeout_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  gdm_state_e state_q;
  logic [SW-1:0] settle_q;
  logic sel_q;
  logic raised;
  logic stop;

  assign raised    = sel_q ? drive_b_o : drive_a_o;
  assign cnt_clr_o = (state_q == ST_IDLE) && start_i;
  assign cnt_en_o  = (state_q == ST_MEASURE) && (raised ^ gate_seen_i) && !sat_i;
  assign stop      = (state_q == ST_MEASURE) && (gate_seen_i || sat_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      settle_q  <= '0;
      sel_q     <= 1'b0;
      drive_a_o <= 1'b0;
      drive_b_o <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sel_q     <= sel_i;
            settle_q  <= '0;
            timeout_o <= 1'b0;
            state_q   <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          settle_q <= settle_q + 1'b1;
          if (settle_q == SETTLE_LAST) begin
            drive_a_o <= !sel_q;
            drive_b_o <= sel_q;
            state_q   <= ST_MEASURE;
          end
        end
        ST_MEASURE: begin
          if (stop) begin
            drive_a_o <= 1'b0;
            drive_b_o <= 1'b0;
            done_o    <= 1'b1;
            timeout_o <= !gate_seen_i;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_one_drive_R3: assert property (@(posedge clk) disable iff (rst)
    !(drive_a_o && drive_b_o));
  assert_quiet_settle_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |-> (!drive_a_o && !drive_b_o));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_timeout_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> done_o);
endmodule

// File: rtl/gate_delay_meter.sv
module gate_delay_meter #(
  parameter int CNT_W      = 12,
  parameter int SYNC_STG   = 2,
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sel_i,
  input  logic             gate_out_i,
  output logic             drive_a_o,
  output logic             drive_b_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             timeout_o
);
  logic gate_seen;
  logic cnt_clr;
  logic cnt_en;
  logic sat;

  gdm_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_i(gate_out_i), .sync_o(gate_seen)
  );

  gdm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .en_i(cnt_en),
    .count_o(count_o), .sat_o(sat)
  );

  gdm_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_i(sel_i),
    .gate_seen_i(gate_seen), .sat_i(sat),
    .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en),
    .drive_a_o(drive_a_o), .drive_b_o(drive_b_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  // R7: the reading is frozen whenever neither counting nor clearing
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !cnt_clr) |=> $stable(count_o));
endmodule

// File: tb/gate_delay_meter_tb.sv
`timescale 1ns/1ps
module gate_delay_meter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sel_i = 1'b0;
  logic gate_out_i;
  logic drive_a_o, drive_b_o, done_o, timeout_o;
  logic [11:0] count_o;

  int checks = 0;
  int errors = 0;
  int da = 1;
  int db = 1;
  bit stuck = 1'b0;
  bit finished = 1'b0;

  logic [63:0] pa = '0;
  logic [63:0] pb = '0;

  always #2.5 clk = ~clk;

  // gate model: output follows each input after a programmable number of edges
  always_ff @(posedge clk) begin
    pa <= {pa[62:0], drive_a_o};
    pb <= {pb[62:0], drive_b_o};
  end
  assign gate_out_i = stuck ? 1'b0 : (pa[da-1] ^ pb[db-1]);

  gate_delay_meter u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_i(sel_i),
    .gate_out_i(gate_out_i), .drive_a_o(drive_a_o), .drive_b_o(drive_b_o),
    .count_o(count_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one measurement; glitch > 0 pulses start again that many cycles in
  task automatic measure(input bit sel, input int exp_cnt, input bit exp_to,
                         input int glitch, input string req);
    bit bad_drive = 1'b0;
    bit seen_done = 1'b0;
    int hold;
    @(negedge clk);
    sel_i = sel;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(count_o == 0, "R2 count cleared", count_o, 0);
    chk(timeout_o == 0, "R2 timeout cleared", timeout_o, 0);
    chk(!drive_a_o && !drive_b_o, "R2 drives low while settling",
        {drive_a_o, drive_b_o}, 0);
    for (int i = 0; i < 5000 && !seen_done; i++) begin
      @(negedge clk);
      if ((drive_a_o && drive_b_o) || (sel ? drive_a_o : drive_b_o)) bad_drive = 1'b1;
      if (glitch > 0 && i == glitch) start_i = 1'b1;
      else start_i = 1'b0;
      if (done_o) seen_done = 1'b1;
    end
    start_i = 1'b0;
    chk(!bad_drive, "R3 only selected drive raised", bad_drive, 0);
    chk(seen_done, {req, " done seen"}, seen_done, 1);
    chk(count_o == exp_cnt, {req, " reading"}, count_o, exp_cnt);
    chk(timeout_o == exp_to, {req, " timeout flag"}, timeout_o, exp_to);
    chk(!drive_a_o && !drive_b_o, "R6 drives low at done", {drive_a_o, drive_b_o}, 0);
    hold = count_o;
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", done_o, 0);
    idle(60);
    chk(count_o == hold, "R7 count held", count_o, hold);
  endtask

  task automatic t_reset;
    chk(!drive_a_o && !drive_b_o, "R1 drives low", {drive_a_o, drive_b_o}, 0);
    chk(count_o == 0, "R1 count zero", count_o, 0);
    chk(!done_o && !timeout_o, "R1 flags low", {done_o, timeout_o}, 0);
  endtask

  task automatic t_input_a(input int d);
    da = d; db = 1;
    measure(1'b0, d + 2, 1'b0, 0, "R4 R5 input A");
  endtask

  task automatic t_input_b(input int d);
    da = 5; db = d;
    measure(1'b1, d + 2, 1'b0, 0, "R10 R5 input B");
  endtask

  task automatic t_busy_start;
    da = 30; db = 1;
    measure(1'b0, 32, 1'b0, 20, "R9 start while busy");
  endtask

  task automatic t_timeout;
    stuck = 1'b1;
    measure(1'b0, 4095, 1'b1, 0, "R8 saturation");
    stuck = 1'b0;
    da = 3;
    measure(1'b0, 5, 1'b0, 0, "R2 R5 after timeout");
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_input_a(5);
    t_input_a(1);
    t_input_b(12);
    t_input_b(40);
    t_busy_start();
    t_timeout();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule